// File: doc/BRIEF.md
# Indexed Error Record Window

This block presents a single 64-bit alias register through which software reaches one of several per-record pseudo-fault generation control registers. A select input names the record. Each record belongs to a node. Only the lowest-numbered record of a node can own a control register, and only if that record's 2-bit injection-capability field is nonzero.

On every read or write strobe, the block checks the select value against two things: the implemented record count, which is an input, and the ownership and capability tables, which are parameters. It then takes one of three actions:
- forward the access to the backing register;
- treat the access as reads-as-zero / writes-ignored;
- treat the access as constrained, which is also reads-as-zero / writes-ignored and additionally pulses a status flag.

Read data is registered.

Top module: `erw_window`

## Requirements
- R1: After reset, all backing registers hold zero, `rd_valid` is 0 and `acc_constrained` is 0.
- R2: A write with `wr_en` high to a forwarding record replaces all 64 bits of that record in the same cycle. A later read of that record returns the written value. With the default tables, the forwarding records are 0, 3 and 6 whenever `rec_count` exceeds the index.
- R3: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and low after a cycle with `rd_en` low. `rd_data` carries the result in that cycle.
- R4: If `rec_count` is 0, or `sel` >= `rec_count`:
  - a read returns zero;
  - a write changes no backing register;
  - `acc_constrained` is 1 in the cycle after the access.
- R5: Capability code 2'b00 means the node does not support injection. If `sel` is in range and the capability of the first record of its node is 2'b00, the access reads as zero, writes are ignored, and `acc_constrained` pulses. With the default tables, this applies to records 2 and 7.
- R6: If `sel` is in range, its node is capable, and `sel` is not the first record of that node, reads return zero, writes are ignored, and `acc_constrained` stays 0. With the default tables, this applies to records 1, 4 and 5. Their first records are 0, 3 and 3.
- R7: A write to one forwarding record leaves every other backing register unchanged.
- R8: `acc_constrained` is 0 in any cycle that does not follow a read or write strobe.
- R9: When `rd_en` and `wr_en` are both high to the same forwarding record, the read returns the value held before the write. The next read returns the new value.
- R10: A select value at or beyond the parameter record count is treated as constrained, even when `rec_count` is larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | SEL_W (4) | Record select value |
| rec_count | input | CNT_W (4) | Implemented record count |
| rd_en | input | 1 | Read strobe for the window |
| wr_en | input | 1 | Write strobe for the window |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| acc_constrained | output | 1 | One-cycle flag marking a constrained access |

## Verification
The assertions assume the following about the inputs:
- `sel`, `rec_count` and the strobes are known and do not change in the middle of a cycle.
- `rec_count` reflects the implemented count at the moment of each access.
- Reads and writes that overlap in one cycle address the same select value.

The stimulus respects these assumptions. It changes inputs only shortly after a rising edge, holds each access for exactly one cycle, and returns the strobes to zero between accesses. It reads back after each ignored write, which shows through the normal read path that the write had no effect.

// File: rtl/erw_pkg.sv
package erw_pkg;
  typedef enum logic [1:0] {
    ACC_FWD    = 2'd0,
    ACC_RAZ    = 2'd1,
    ACC_CONSTR = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/erw_decode.sv
module erw_decode
  import erw_pkg::*;
#(
  parameter int NREC  = 8,
  parameter int IDX_W = $clog2(NREC),
  parameter int SEL_W = 4,
  parameter int CNT_W = 4,
  parameter logic [NREC-1:0][IDX_W-1:0] FIRST_IDX = '0,
  parameter logic [NREC-1:0][1:0]       INJ_CAP   = '0
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] rec_count,
  output acc_kind_e        kind,
  output logic [IDX_W-1:0] idx
);
  localparam int NR_W  = $clog2(NREC + 1);
  localparam int M1    = (SEL_W > CNT_W) ? SEL_W : CNT_W;
  localparam int CMP_W = (M1 > NR_W) ? M1 : NR_W;

  logic [CMP_W-1:0] sel_x;
  logic [CMP_W-1:0] cnt_x;
  logic             in_range;
  logic [IDX_W-1:0] first_idx;
  logic [1:0]       cap;

  always_comb begin
    sel_x     = CMP_W'(sel);
    cnt_x     = CMP_W'(rec_count);
    in_range  = (cnt_x != '0) && (sel_x < cnt_x) && (sel_x < CMP_W'(NREC));
    idx       = sel[IDX_W-1:0];
    first_idx = FIRST_IDX[idx];
    cap       = INJ_CAP[first_idx];
    if (!in_range)              kind = ACC_CONSTR;
    else if (cap == 2'b00)      kind = ACC_CONSTR;
    else if (first_idx != idx)  kind = ACC_RAZ;
    else                        kind = ACC_FWD;
  end
endmodule

// File: rtl/erw_regbank.sv
module erw_regbank #(
  parameter int NREC   = 8,
  parameter int IDX_W  = $clog2(NREC),
  parameter int DATA_W = 64,
  parameter logic [NREC-1:0][IDX_W-1:0] FIRST_IDX = '0,
  parameter logic [NREC-1:0][1:0]       INJ_CAP   = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_fire,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NREC-1:0][DATA_W-1:0]   regs_q
);
  for (genvar i = 0; i < NREC; i++) begin : g_rec
    localparam bit HAS_REG = (int'(FIRST_IDX[i]) == i) && (INJ_CAP[i] != 2'b00);
    if (HAS_REG) begin : g_real
      logic              en;
      logic [DATA_W-1:0] d;
      logic [DATA_W-1:0] q;

      always_comb begin
        en = wr_fire && (wr_idx == IDX_W'(i));
        d  = en ? wr_data : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end

      assign regs_q[i] = q;
    end else begin : g_absent
      assign regs_q[i] = '0;
    end
  end
endmodule

// File: rtl/erw_rdport.sv
module erw_rdport
  import erw_pkg::*;
#(
  parameter int NREC   = 8,
  parameter int IDX_W  = $clog2(NREC),
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic                        wr_en,
  input  acc_kind_e                   kind,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NREC-1:0][DATA_W-1:0] regs_q,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_valid,
  output logic                        acc_constrained
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              vld_d, vld_q;
  logic              con_d, con_q;

  always_comb begin
    data_d = data_q;
    if (rd_en) data_d = (kind == ACC_FWD) ? regs_q[idx] : '0;
    vld_d = rd_en;
    con_d = (rd_en || wr_en) && (kind == ACC_CONSTR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      con_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
      con_q  <= con_d;
    end
  end

  assign rd_data         = data_q;
  assign rd_valid        = vld_q;
  assign acc_constrained = con_q;
endmodule

// File: rtl/erw_window.sv
module erw_window
  import erw_pkg::*;
#(
  parameter int NREC   = 8,
  parameter int IDX_W  = $clog2(NREC),
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 64,
  parameter logic [NREC-1:0][IDX_W-1:0] FIRST_IDX =
    {3'd7, 3'd6, 3'd3, 3'd3, 3'd3, 3'd2, 3'd0, 3'd0},
  parameter logic [NREC-1:0][1:0] INJ_CAP =
    {2'b00, 2'b11, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b01}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CNT_W-1:0]  rec_count,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              acc_constrained
);
  acc_kind_e                   kind;
  logic [IDX_W-1:0]            idx;
  logic                        wr_fire;
  logic [NREC-1:0][DATA_W-1:0] regs_q;

  erw_decode #(
    .NREC(NREC), .IDX_W(IDX_W), .SEL_W(SEL_W), .CNT_W(CNT_W),
    .FIRST_IDX(FIRST_IDX), .INJ_CAP(INJ_CAP)
  ) dec_i (
    .sel(sel), .rec_count(rec_count), .kind(kind), .idx(idx)
  );

  assign wr_fire = wr_en && (kind == ACC_FWD);

  erw_regbank #(
    .NREC(NREC), .IDX_W(IDX_W), .DATA_W(DATA_W),
    .FIRST_IDX(FIRST_IDX), .INJ_CAP(INJ_CAP)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(idx),
    .wr_data(wr_data), .regs_q(regs_q)
  );

  erw_rdport #(
    .NREC(NREC), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) rd_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .kind(kind),
    .idx(idx), .regs_q(regs_q), .rd_data(rd_data), .rd_valid(rd_valid),
    .acc_constrained(acc_constrained)
  );
endmodule

// File: rtl/erw_window_chk.sv
module erw_window_chk #(
  parameter int NREC   = 8,
  parameter int IDX_W  = $clog2(NREC),
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 64,
  parameter logic [NREC-1:0][IDX_W-1:0] FIRST_IDX = '0,
  parameter logic [NREC-1:0][1:0]       INJ_CAP   = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel,
  input logic [CNT_W-1:0]  rec_count,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              acc_constrained
);
  localparam int CMP_W = ((SEL_W > CNT_W) ? SEL_W : CNT_W) + 1;

  logic             in_rng;
  logic [IDX_W-1:0] s_idx;
  logic             capable;
  logic             not_first;

  always_comb begin
    in_rng    = (CMP_W'(rec_count) != '0) && (CMP_W'(sel) < CMP_W'(rec_count))
                && (CMP_W'(sel) < CMP_W'(NREC));
    s_idx     = sel[IDX_W-1:0];
    capable   = INJ_CAP[FIRST_IDX[s_idx]] != 2'b00;
    not_first = FIRST_IDX[s_idx] != s_idx;
  end

  assert_valid_follows_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_valid_without_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_flag_needs_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> !acc_constrained);
  assert_out_of_range_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && !in_rng |=> acc_constrained);
  assert_out_of_range_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !in_rng |=> rd_data == '0);
  assert_incapable_node_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && in_rng && !capable |=> acc_constrained && rd_data == '0);
  assert_non_first_raz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && in_rng && capable && not_first |=> !acc_constrained && rd_data == '0);
endmodule

bind erw_window erw_window_chk #(
  .NREC(NREC), .IDX_W(IDX_W), .SEL_W(SEL_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
  .FIRST_IDX(FIRST_IDX), .INJ_CAP(INJ_CAP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rec_count(rec_count), .rd_en(rd_en),
  .wr_en(wr_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .acc_constrained(acc_constrained)
);

// File: tb/erw_window_tb.sv
module erw_window_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel = '0;
  logic [3:0]  rec_count = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic        acc_constrained;

  always #(CLK_PERIOD/2) clk = ~clk;

  erw_window dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rec_count(rec_count),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .acc_constrained(acc_constrained)
  );

  // Tables as stated in the requirements (R2, R5, R6)
  localparam logic [7:0][2:0] B_FIRST = {3'd7, 3'd6, 3'd3, 3'd3, 3'd3, 3'd2, 3'd0, 3'd0};
  localparam logic [7:0][1:0] B_CAP   = {2'b00, 2'b11, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b01};

  typedef struct {
    int          due;
    bit          is_rd;
    logic [63:0] data;
    bit          flag;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] model [8];
  int          cyc = 0;
  int          errs = 0;
  int          checks = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // 0 = forward, 1 = reads-as-zero, 2 = constrained
  function automatic int classify(input logic [3:0] s, input logic [3:0] c);
    int f;
    if (c == 0 || s >= c || s >= 8) return 2;
    f = int'(B_FIRST[s[2:0]]);
    if (B_CAP[f] == 2'b00) return 2;
    if (f != int'(s)) return 1;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit rd, input bit wr, input logic [3:0] s,
                     input logic [3:0] c, input logic [63:0] d, input string tag);
    exp_t e;
    int k;
    @(posedge clk); #1;
    rd_en = rd; wr_en = wr; sel = s; rec_count = c; wr_data = d;
    k = classify(s, c);
    e.due   = cyc + 1;
    e.is_rd = rd;
    e.data  = (k == 0) ? model[s[2:0]] : 64'h0;
    e.flag  = (k == 2);
    e.tag   = tag;
    if (wr && k == 0) model[s[2:0]] = d;
    sb.push_back(e);
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  // Monitor: compares outputs against queued expectations at falling edges
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() != 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(rd_valid == e.is_rd, {e.tag, " R3 valid"}, 64'(rd_valid), 64'(e.is_rd));
        if (e.is_rd) check(rd_data == e.data, {e.tag, " data"}, rd_data, e.data);
        check(acc_constrained == e.flag, {e.tag, " flag"}, 64'(acc_constrained), 64'(e.flag));
      end else begin
        check(!rd_valid, "R3 idle valid", 64'(rd_valid), 64'h0);
        check(!acc_constrained, "R8 idle flag", 64'(acc_constrained), 64'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R1 reset valid", 64'(rd_valid), 64'h0);
    check(acc_constrained == 1'b0, "R1 reset flag", 64'(acc_constrained), 64'h0);
    rst_n = 1'b1;

    acc(1, 0, 4'd0, 4'd8, '0, "R1 rec0");
    acc(1, 0, 4'd3, 4'd8, '0, "R1 rec3");
    acc(1, 0, 4'd6, 4'd8, '0, "R1 rec6");

    acc(0, 1, 4'd0, 4'd8, 64'hA5A5_0000_1234_5678, "R2 wr0");
    acc(0, 1, 4'd3, 4'd8, 64'h0123_4567_89AB_CDEF, "R2 wr3");
    acc(0, 1, 4'd6, 4'd8, 64'hDEAD_BEEF_CAFE_F00D, "R2 wr6");
    acc(1, 0, 4'd0, 4'd8, '0, "R2 R7 rd0");
    acc(1, 0, 4'd3, 4'd8, '0, "R2 R7 rd3");
    acc(1, 0, 4'd6, 4'd8, '0, "R2 R7 rd6");
    acc(0, 1, 4'd3, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R2 ones");
    acc(1, 0, 4'd3, 4'd8, '0, "R2 ones rd");
    acc(1, 0, 4'd0, 4'd8, '0, "R7 rd0 kept");

    acc(0, 1, 4'd1, 4'd8, 64'h1111, "R6 wr1");
    acc(0, 1, 4'd4, 4'd8, 64'h4444, "R6 wr4");
    acc(0, 1, 4'd5, 4'd8, 64'h5555, "R6 wr5");
    acc(1, 0, 4'd1, 4'd8, '0, "R6 rd1");
    acc(1, 0, 4'd5, 4'd8, '0, "R6 rd5");
    acc(1, 0, 4'd0, 4'd8, '0, "R6 rd0 kept");
    acc(1, 0, 4'd3, 4'd8, '0, "R6 rd3 kept");

    acc(0, 1, 4'd2, 4'd8, 64'h2222, "R5 wr2");
    acc(1, 0, 4'd2, 4'd8, '0, "R5 rd2");
    acc(1, 0, 4'd7, 4'd8, '0, "R5 rd7");

    acc(1, 0, 4'd6, 4'd4, '0, "R4 rd6 cnt4");
    acc(0, 1, 4'd6, 4'd4, 64'h6666, "R4 wr6 cnt4");
    acc(1, 0, 4'd6, 4'd8, '0, "R4 rd6 kept");
    acc(1, 0, 4'd0, 4'd0, '0, "R4 cnt0 rd");
    acc(0, 1, 4'd0, 4'd0, 64'h7777, "R4 cnt0 wr");
    acc(1, 0, 4'd0, 4'd8, '0, "R4 rd0 kept");

    acc(1, 0, 4'd9, 4'd15, '0, "R10 sel9");
    acc(0, 1, 4'd15, 4'd15, 64'h9, "R10 sel15 wr");

    acc(1, 1, 4'd0, 4'd8, 64'h0BAD_F00D_0000_0001, "R9 rdwr");
    acc(1, 0, 4'd0, 4'd8, '0, "R9 rd new");

    repeat (4) @(posedge clk);
    @(negedge clk);
    done = 1;
    check(sb.size() == 0, "R3 queue drained", 64'(sb.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule